// File: doc/BRIEF.md
# Bit-Count SPI Slave Shift Engine

This block is the receiving end of a serial peripheral link. It moves a programmed number of bits, anywhere from 1 to 255, in a single operation. Local logic arms it with a one-cycle start pulse. The pulse carries a bit count and a left-aligned preload vector. While the remote master clocks the link, the block shifts the preload out on MISO and shifts MOSI in through the same register. When the last requested bit has been sampled, the received bits appear right-aligned in `rx_vec` and the `done` flag rises.

The link timing uses clock phase 1 only: the leading SCK edge (away from idle) presents a bit, and the trailing edge (back to idle) samples it. The `cpol` input selects the idle level of SCK. SCK, MOSI, the active-low select and the timeout input all cross into the system clock domain through a two-flop synchronizer, and the edges are found by comparing successive synchronized samples. A master can stop early after sending fewer bits than requested. For that case, a high level on `timeout` ends the operation, raises `aborted` and reports how many bits actually arrived.

The controller has two states. `S_IDLE` waits for an accepted start. `S_RUN` shifts bits. There are three transitions: *arm* (`S_IDLE` to `S_RUN`, on start with a non-zero count), *complete* (`S_RUN` to `S_IDLE`, on the trailing edge of the final bit) and *abort* (`S_RUN` to `S_IDLE`, on a synchronized timeout level, which wins over an edge in the same cycle).

Top module: `spi_bc_slave`

## Requirements
- R1: After an accepted start with count N (1..255), the block sets `done`, sets `bits_done` to N and returns to idle on the trailing edge of bit N. No further edges are counted after that.
- R2: In `S_RUN`, MISO changes only on a leading SCK edge. MOSI is captured only on a trailing SCK edge.
- R3: With `cpol`=0, SCK idles low, so the leading edge is rising. With `cpol`=1, SCK idles high, so the leading edge is falling. Both settings transfer identically.
- R4: A high `timeout` level during `S_RUN` sets `aborted`, keeps `done` low, sets `bits_done` to the number of bits sampled so far (0 allowed) and returns to idle.
- R5: Data leaves MSB first from a left-aligned preload. The k-th bit presented (k from 0) is `preload[254-k]`, and MISO equals `preload[254]` from the accepted start until the first leading edge.
- R6: At completion or abort with M received bits, the first received bit sits at `rx_vec[M-1]` and the last at `rx_vec[0]`. All bits at positions M and above are zero.
- R7: While `ss_n` is high, SCK edges neither shift nor count.
- R8: A start while in `S_RUN` is ignored. A start with count 0 is ignored, so flags, `bits_done` and `rx_vec` keep their values.
- R9: After reset, `done`, `aborted`, `bits_done`, `rx_vec` and `miso` are all zero.
- R10: `done` and `aborted` are never high together. They hold until the next accepted start, which clears both, along with `bits_done` and `rx_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level (0 low, 1 high) |
| start | input | 1 | One-cycle arm pulse |
| bit_count | input | 8 | Requested bit count, 1..255 |
| preload | input | 255 | Transmit bits, left-aligned, MSB sent first |
| ss_n | input | 1 | Active-low slave select from master |
| sck | input | 1 | Serial clock from master |
| mosi | input | 1 | Serial data from master |
| timeout | input | 1 | High level aborts a running operation |
| miso | output | 1 | Serial data to master |
| rx_vec | output | 255 | Received bits, right-aligned |
| bits_done | output | 8 | Bits transferred in the last operation |
| done | output | 1 | Operation completed with full count |
| aborted | output | 1 | Operation ended by timeout |

## Verification
Several internal faults show up at distinct points on the ports.
- A wrong bit counter shows up at the end of the operation. Either `done` rises a full SCK period early or late, or `bits_done` and the position of the received bits in `rx_vec` disagree with the count that was driven.
- A wrong edge decode, such as a swapped polarity or a swapped phase, corrupts the first bit the master samples from MISO within one SCK period. It also shifts every received bit by one position.
- A controller that stays in `S_RUN` after a timeout never raises `aborted`. The scoreboard notices this on the next expected result.

// File: rtl/spi_bc_pkg.sv
package spi_bc_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } bc_state_t;
endpackage

// File: rtl/spi_bc_sync.sv
module spi_bc_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[k] <= RST_VAL;
                else        chain[k] <= chain[k-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_bc_edge.sv
module spi_bc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic sck_s,
    input  logic sel_s,
    output logic lead,
    output logic trail
);
    logic sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // leading edge moves away from the idle level, trailing returns to it
    assign lead  = sel_s && (sck_s != sck_d) && (sck_s != cpol);
    assign trail = sel_s && (sck_s != sck_d) && (sck_s == cpol);
endmodule

// File: rtl/spi_bc_shift.sv
module spi_bc_shift #(
    parameter int VEC_W = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] load_val,
    input  logic             present,
    input  logic             capture,
    input  logic             din,
    output logic             dout,
    output logic [VEC_W-1:0] sh_q,
    output logic [VEC_W-1:0] sh_nx
);
    assign sh_nx = {sh_q[VEC_W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            dout <= 1'b0;
        end else if (load) begin
            sh_q <= load_val;
            dout <= load_val[VEC_W-1];
        end else begin
            if (present) dout <= sh_q[VEC_W-1];
            if (capture) sh_q <= sh_nx;
        end
    end
endmodule

// File: rtl/spi_bc_slave.sv
module spi_bc_slave
    import spi_bc_pkg::*;
#(
    parameter int MAX_BITS = 255,
    parameter int SYNC_STAGES = 2,
    localparam int VEC_W = MAX_BITS,
    localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic             start,
    input  logic [CNT_W-1:0] bit_count,
    input  logic [VEC_W-1:0] preload,
    input  logic             ss_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             timeout,
    output logic             miso,
    output logic [VEC_W-1:0] rx_vec,
    output logic [CNT_W-1:0] bits_done,
    output logic             done,
    output logic             aborted
);
    function automatic logic [VEC_W-1:0] low_mask(input logic [CNT_W-1:0] n);
        logic [VEC_W-1:0] m;
        for (int i = 0; i < VEC_W; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    // synchronized pins: {timeout, ss_n, mosi, sck}
    logic [3:0] pins_s;
    logic       sck_s, mosi_s, ssn_s, to_s;

    spi_bc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({timeout, ss_n, mosi, sck}),
        .q(pins_s)
    );
    assign {to_s, ssn_s, mosi_s, sck_s} = pins_s;

    logic lead, trail;
    spi_bc_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cpol(cpol),
        .sck_s(sck_s), .sel_s(!ssn_s),
        .lead(lead), .trail(trail)
    );

    bc_state_t        state_q, state_d;
    logic [CNT_W-1:0] target_q, cnt_q, cnt_inc;
    logic             go, run_ok, last_bit;
    logic [VEC_W-1:0] sh_q, sh_nx;

    assign go       = start && (state_q == S_IDLE) && (bit_count != '0);
    assign run_ok   = (state_q == S_RUN) && !to_s;
    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign last_bit = run_ok && trail && (cnt_inc == target_q);

    spi_bc_shift #(.VEC_W(VEC_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .load(go), .load_val(preload),
        .present(run_ok && lead), .capture(run_ok && trail),
        .din(mosi_s), .dout(miso),
        .sh_q(sh_q), .sh_nx(sh_nx)
    );

    // next-state decode: arm, complete, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (go) state_d = S_RUN;
            S_RUN: begin
                if (to_s)          state_d = S_IDLE;
                else if (last_bit) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q  <= '0;
            cnt_q     <= '0;
            rx_vec    <= '0;
            bits_done <= '0;
            done      <= 1'b0;
            aborted   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (go) begin
                    target_q  <= bit_count;
                    cnt_q     <= '0;
                    rx_vec    <= '0;
                    bits_done <= '0;
                    done      <= 1'b0;
                    aborted   <= 1'b0;
                end
                S_RUN: begin
                    if (to_s) begin
                        aborted   <= 1'b1;
                        bits_done <= cnt_q;
                        rx_vec    <= sh_q & low_mask(cnt_q);
                    end else if (trail) begin
                        cnt_q <= cnt_inc;
                        if (last_bit) begin
                            done      <= 1'b1;
                            bits_done <= target_q;
                            rx_vec    <= sh_nx & low_mask(target_q);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // assertions guarding the controller
    assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && aborted));
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (cnt_q < target_q));
    assert_done_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (bits_done == target_q));
    assert_miso_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(state_q == S_RUN && lead) && !go) |=> $stable(miso));
    assert_abort_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && to_s) |=> (state_q == S_IDLE && aborted && !done));
    assert_rx_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done || aborted) |-> ((rx_vec & ~low_mask(bits_done)) == '0));
    assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (!done && !aborted && state_q == S_RUN));
endmodule

// File: tb/spi_bc_slave_test.sv
module spi_bc_slave_test;
    localparam int W = 255;
    localparam int H = 6;   // system clocks per SCK half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpol = 1'b0, start = 1'b0, ss_n = 1'b1, sck = 1'b0, mosi = 1'b0, timeout = 1'b0;
    logic [7:0] bit_count = '0;
    logic [W-1:0] preload = '0;
    logic miso, done, aborted;
    logic [W-1:0] rx_vec;
    logic [7:0] bits_done;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    spi_bc_slave uut (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .start(start),
        .bit_count(bit_count), .preload(preload), .ss_n(ss_n),
        .sck(sck), .mosi(mosi), .timeout(timeout), .miso(miso),
        .rx_vec(rx_vec), .bits_done(bits_done), .done(done), .aborted(aborted)
    );

    typedef struct {
        logic [W-1:0] rx;
        logic [7:0]   n;
        logic         ab;
        string        tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [W-1:0] lowm(input int n);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = (i < n);
        return m;
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pol(input logic p);
        cpol = p; sck = p; tick(10);
    endtask

    task automatic arm(input int n, input logic [W-1:0] pl);
        bit_count = 8'(n); preload = pl; start = 1'b1;
        tick(1); start = 1'b0; tick(4);
    endtask

    // one bit with clock phase 1; returns the MISO value seen at the trailing edge
    task automatic bit_cycle(input logic b, output logic got);
        sck = ~cpol; mosi = b; tick(H);
        got = miso;
        sck = cpol; tick(H);
    endtask

    // full driver: pushes expectation, runs bits, checks MISO stream
    task automatic xfer(input string tag, input int n, input int stop_at,
                        input logic [W-1:0] pl, input logic [W-1:0] d);
        exp_t e;
        int k;
        logic got;
        logic [W-1:0] mgot, mexp;
        k = (stop_at < n) ? stop_at : n;
        e.tag = tag; e.ab = (stop_at < n); e.n = 8'(k);
        e.rx = (d >> (n - k)) & lowm(k);
        sb.push_back(e);
        mgot = '0; mexp = '0;
        ss_n = 1'b0; tick(2);
        arm(n, pl);
        // R5: MISO holds preload MSB before first leading edge
        chk({tag, " R5 first bit"}, W'(miso), W'(pl[W-1]));
        for (int i = 0; i < k; i++) begin
            bit_cycle(d[n-1-i], got);
            mgot[i] = got;
            mexp[i] = pl[W-1-i];
        end
        tick(6);
        if (e.ab) begin
            timeout = 1'b1; tick(6); timeout = 1'b0;
            // edges after abort must not matter
            bit_cycle(1'b1, got);
        end
        tick(4);
        ss_n = 1'b1; tick(2);
        chk({tag, " R2 R5 miso stream"}, mgot, mexp);
    endtask

    // monitor: compare each new result against the scoreboard
    initial begin
        logic seen;
        seen = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (done || aborted) && !seen) begin
                seen = 1'b1;
                if (sb.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R1 unexpected result act=%0d exp=none", bits_done);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({e.tag, " R1 R4 count"}, W'(bits_done), W'(e.n));
                    chk({e.tag, " R6 rx"}, rx_vec, e.rx);
                    chk({e.tag, " R4 R10 flags"}, W'({done, aborted}), W'({!e.ab, e.ab}));
                end
            end else if (!done && !aborted) begin
                seen = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] pat, pl2;
        logic got;
        pat = {8{32'hA5C3_96E1}} ^ {W{1'b0}};
        pl2 = ~pat;
        tick(3); rst_n = 1'b1; tick(3);
        // R9 reset state
        chk("R9 reset flags", W'({done, aborted, miso}), '0);
        chk("R9 reset count", W'(bits_done), '0);
        chk("R9 reset rx", rx_vec, '0);

        set_pol(1'b0);
        xfer("R1 R3 8b pol0", 8, 999, pl2, W'(8'hB4));
        xfer("R1 1b", 1, 999, pat, W'(1'b1));
        xfer("R1 255b", 255, 999, pl2, pat);

        // R8: zero count start ignored
        bit_count = 8'd0; start = 1'b1; tick(1); start = 1'b0; tick(4);
        chk("R8 zero start done", W'({done, aborted}), W'(2'b10));
        chk("R8 zero start count", W'(bits_done), W'(8'd255));

        set_pol(1'b1);
        xfer("R3 16b pol1", 16, 999, pat, W'(16'h3C5A));
        xfer("R4 abort 5 of 12", 12, 5, pl2, W'(12'hD27));
        xfer("R4 abort 0 of 9", 9, 0, pat, W'(9'h1FF));

        set_pol(1'b0);
        // R7: edges with ss_n high ignored
        begin
            exp_t e;
            e.tag = "R7 ss_n high"; e.ab = 1'b0; e.n = 8'd6; e.rx = W'(6'b101101);
            sb.push_back(e);
            ss_n = 1'b0; tick(2);
            arm(6, pat);
            ss_n = 1'b1; tick(4);
            for (int i = 0; i < 4; i++) bit_cycle(1'b0, got);
            ss_n = 1'b0; tick(4);
            for (int i = 5; i >= 0; i--) bit_cycle(W'(6'b101101) >> i, got);
            tick(8);
        end

        // R8: start while running ignored
        begin
            exp_t e;
            e.tag = "R8 start in run"; e.ab = 1'b0; e.n = 8'd10; e.rx = W'(10'h2D3);
            sb.push_back(e);
            ss_n = 1'b0; tick(2);
            arm(10, pl2);
            for (int i = 9; i >= 7; i--) bit_cycle(W'(10'h2D3) >> i, got);
            bit_count = 8'd3; preload = pat; start = 1'b1; tick(1); start = 1'b0; tick(3);
            for (int i = 6; i >= 0; i--) bit_cycle(W'(10'h2D3) >> i, got);
            tick(8);
            ss_n = 1'b1;
        end

        tick(10);
        chk("R1 scoreboard drained", W'(sb.size()), '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule